// File: doc/BRIEF.md
# Serial ADC Calibration Readout Controller

This block drives a four-channel, 16-bit successive-approximation ADC over a four-wire serial link: convert strobe, serial clock, configuration data toward the ADC, and result data from the ADC. It is used during DAC calibration to measure analog outputs. The host asks for a sample with a valid/ready command that names a channel. The controller raises the convert strobe and holds it for a fixed conversion time. It then runs one burst of serial clocks, and hands the captured word back to the host through a valid/ready result port.

Within each burst two transfers happen together. The result of the conversion that just finished is shifted out of the ADC, and the configuration word that selects the channel for the next conversion is shifted in. Because of this overlap, every result belongs to the channel that was requested one command earlier. The controller tags each result with that channel. Before the first command after reset, no channel has been chosen through the controller, so the first result carries a flag that marks it as not usable.

Top module: `adc_cal_reader`

## Requirements
- R1: After reset, cmd_ready is 1, and res_valid, adc_cnv, adc_sck and adc_din are all 0.
- R2: A command is accepted only on a cycle with cmd_valid and cmd_ready both high. adc_cnv rises on the next cycle and stays high for exactly CONV_CYCLES cycles. adc_cnv never rises without an accepted command, and cmd_ready is low from acceptance until the result has been taken.
- R3: adc_sck is low whenever adc_cnv is high. After adc_cnv falls, adc_sck stays low for SCK_HALF cycles. It then gives exactly DATA_W pulses, each high for SCK_HALF cycles and separated by SCK_HALF low cycles, and it ends low.
- R4: adc_sdout is sampled on each rising adc_sck, most significant bit first. res_data equals the DATA_W sampled bits.
- R5: During a burst, adc_din carries the configuration word, most significant bit first. The word is bit 15 = 1 (configuration update), bits 14:13 = the accepted channel, and all other bits 0. adc_din changes only on falling adc_sck edges, so it is stable at every rising edge.
- R6: res_chan equals the channel of the previously accepted command. res_primed is 0 for the first result after reset and 1 for every later result.
- R7: res_valid stays high, with res_data and res_chan unchanged, until res_ready is seen. While a result is pending, no command is accepted even if cmd_valid is high.
- R8: cmd_chan is ignored except in the acceptance cycle. Changes to it while idle without cmd_valid, or while busy, affect neither adc_cnv nor the configuration word sent on adc_din.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host requests a conversion |
| cmd_chan | input | 2 | Channel for the configuration word of this command |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Host takes the result |
| res_data | output | 16 | Captured conversion result |
| res_chan | output | 2 | Channel the result belongs to |
| res_primed | output | 1 | 0 for the first result after reset, otherwise 1 |
| adc_cnv | output | 1 | Convert strobe to the ADC |
| adc_sck | output | 1 | Serial clock to the ADC |
| adc_din | output | 1 | Serial configuration data to the ADC |
| adc_sdout | input | 1 | Serial result data from the ADC |

## Verification
The hardest case to reach from the ports is the one-command lag. It needs every pairing of the previous and the current channel, and each of those results must be compared with what a separately modelled ADC converted under the configuration it actually latched. The stimulus walks a channel sequence in which each of the sixteen ordered pairs appears once. The ADC model applies only the word it shifted in on adc_din. The host changes cmd_chan and raises cmd_valid while busy and while a result is held, so that acceptance-only sampling and back-pressure both show up as a wrong tag or an extra conversion.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } adcr_state_e;

endpackage

// File: rtl/adcr_sck_gen.sv
module adcr_sck_gen #(
    parameter int SCK_HALF = 2,
    parameter int DATA_W   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall,
    output logic last
);
    localparam int PH_W = $clog2(SCK_HALF + 1);
    localparam int BC_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            sck;
        logic [BC_W-1:0] bits;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        rise  = 1'b0;
        fall  = 1'b0;
        last  = 1'b0;
        if (!run) begin
            gen_d.ph   = '0;
            gen_d.sck  = 1'b0;
            gen_d.bits = '0;
        end else if (gen_q.ph == PH_W'(SCK_HALF - 1)) begin
            gen_d.ph  = '0;
            gen_d.sck = !gen_q.sck;
            if (gen_q.sck) begin
                fall       = 1'b1;
                gen_d.bits = gen_q.bits + 1'b1;
                if (gen_q.bits == BC_W'(DATA_W - 1)) begin
                    last = 1'b1;
                end
            end else begin
                rise = 1'b1;
            end
        end else begin
            gen_d.ph = gen_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign sck = gen_q.sck;

endmodule

// File: rtl/adcr_shifter.sv
module adcr_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdout,
    output logic              din,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] cap;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.cfg = load_word;
        end else if (fall) begin
            sh_d.cfg = {sh_q.cfg[DATA_W-2:0], 1'b0};
        end
        if (rise) begin
            sh_d.cap = {sh_q.cap[DATA_W-2:0], sdout};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign din  = sh_q.cfg[DATA_W-1];
    assign data = sh_q.cap;

endmodule

// File: rtl/adc_cal_reader.sv
module adc_cal_reader #(
    parameter int NUM_CHAN    = 4,
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 30,
    parameter int SCK_HALF    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [$clog2(NUM_CHAN)-1:0] cmd_chan,
    output logic                        cmd_ready,
    output logic                        res_valid,
    input  logic                        res_ready,
    output logic [DATA_W-1:0]           res_data,
    output logic [$clog2(NUM_CHAN)-1:0] res_chan,
    output logic                        res_primed,
    output logic                        adc_cnv,
    output logic                        adc_sck,
    output logic                        adc_din,
    input  logic                        adc_sdout
);
    import adcr_pkg::*;

    localparam int CHAN_W = $clog2(NUM_CHAN);
    localparam int CNT_W  = $clog2(CONV_CYCLES + 1);
    localparam int PAD_W  = DATA_W - 1 - CHAN_W;

    typedef struct packed {
        adcr_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic              cnv;
        logic [CHAN_W-1:0] cur_ch;
        logic [CHAN_W-1:0] tag_ch;
        logic              primed;
        logic              rvalid;
        logic [CHAN_W-1:0] rchan;
        logic              rprimed;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              run;
    logic              rise, fall, last;
    logic              load;
    logic [DATA_W-1:0] cfg_word;

    assign cfg_word = {1'b1, cmd_chan, {PAD_W{1'b0}}};
    assign load     = (ctl_q.state == ST_IDLE) && cmd_valid;
    assign run      = (ctl_q.state == ST_SHIFT);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctl_d.state  = ST_CONV;
                    ctl_d.cnv    = 1'b1;
                    ctl_d.cnt    = '0;
                    ctl_d.cur_ch = cmd_chan;
                end
            end
            ST_CONV: begin
                if (ctl_q.cnt == CNT_W'(CONV_CYCLES - 1)) begin
                    ctl_d.state = ST_SHIFT;
                    ctl_d.cnv   = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (last) begin
                    ctl_d.state   = ST_DONE;
                    ctl_d.rvalid  = 1'b1;
                    ctl_d.rchan   = ctl_q.tag_ch;
                    ctl_d.rprimed = ctl_q.primed;
                    ctl_d.tag_ch  = ctl_q.cur_ch;
                    ctl_d.primed  = 1'b1;
                end
            end
            ST_DONE: begin
                if (res_ready) begin
                    ctl_d.state  = ST_IDLE;
                    ctl_d.rvalid = 1'b0;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    adcr_sck_gen #(
        .SCK_HALF (SCK_HALF),
        .DATA_W   (DATA_W)
    ) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sck   (adc_sck),
        .rise  (rise),
        .fall  (fall),
        .last  (last)
    );

    adcr_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (cfg_word),
        .rise      (rise),
        .fall      (fall),
        .sdout     (adc_sdout),
        .din       (adc_din),
        .data      (res_data)
    );

    assign cmd_ready  = (ctl_q.state == ST_IDLE);
    assign res_valid  = ctl_q.rvalid;
    assign res_chan   = ctl_q.rchan;
    assign res_primed = ctl_q.rprimed;
    assign adc_cnv    = ctl_q.cnv;

endmodule

// File: rtl/adcr_checker.sv
module adcr_checker #(
    parameter int NUM_CHAN    = 4,
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 30
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_valid,
    input logic                        cmd_ready,
    input logic                        res_valid,
    input logic                        res_ready,
    input logic [DATA_W-1:0]           res_data,
    input logic [$clog2(NUM_CHAN)-1:0] res_chan,
    input logic                        adc_cnv,
    input logic                        adc_sck,
    input logic                        adc_din
);
    int cnv_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_len <= 0;
        end else if (adc_cnv) begin
            cnv_len <= cnv_len + 1;
        end else begin
            cnv_len <= 0;
        end
    end

    AST_ACCEPT_STARTS_CNV: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> adc_cnv && !cmd_ready); // R2

    AST_CNV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnv) |-> cnv_len == CONV_CYCLES); // R2

    AST_CNV_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnv |-> cnv_len < CONV_CYCLES); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !adc_cnv && !adc_sck && !res_valid); // R2

    AST_NO_SCK_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnv |-> !adc_sck); // R3

    AST_DIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready && !adc_cnv && !$past(adc_cnv) && !$stable(adc_din) |-> $fell(adc_sck)); // R5

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_chan)); // R7

    AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !cmd_ready); // R7

endmodule

bind adc_cal_reader adcr_checker #(
    .NUM_CHAN    (NUM_CHAN),
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_chan  (res_chan),
    .adc_cnv   (adc_cnv),
    .adc_sck   (adc_sck),
    .adc_din   (adc_din)
);

// File: tb/adc_cal_reader_test.sv
module adc_cal_reader_test;
    localparam int CONV = 5;
    localparam int HALF = 2;
    localparam int W    = 16;
    localparam int NCMD = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_chan = 2'd0;
    logic        cmd_ready;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [15:0] res_data;
    logic [1:0]  res_chan;
    logic        res_primed;
    logic        adc_cnv, adc_sck, adc_din;
    logic        adc_sdout = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    adc_cal_reader #(
        .NUM_CHAN(4), .DATA_W(W), .CONV_CYCLES(CONV), .SCK_HALF(HALF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
        .cmd_ready(cmd_ready), .res_valid(res_valid), .res_ready(res_ready),
        .res_data(res_data), .res_chan(res_chan), .res_primed(res_primed),
        .adc_cnv(adc_cnv), .adc_sck(adc_sck), .adc_din(adc_din),
        .adc_sdout(adc_sdout)
    );

    function automatic logic [15:0] sample_val(input int ch, input int n);
        return 16'((((ch + 1) * 997) ^ (n * 4369) ^ 32'h8001) & 32'hFFFF);
    endfunction

    // ADC model: converts the channel held in its own config register
    logic [15:0] m_sh = '0;
    logic [15:0] m_din = '0;
    logic [15:0] m_last_din = '0;
    logic [1:0]  m_cfg_ch = 2'd0;
    int          m_rises = 0;
    int          m_conv_n = 0;
    int          cnv_rises = 0;

    always @(posedge adc_cnv or posedge adc_sck or negedge adc_sck) begin
        if (adc_cnv) begin
            m_sh = sample_val(int'(m_cfg_ch), m_conv_n);
            m_conv_n++;
            cnv_rises++;
            m_rises = 0;
            adc_sdout = m_sh[15];
        end else if (adc_sck) begin
            m_din = {m_din[14:0], adc_din};
            m_rises++;
        end else begin
            m_sh = {m_sh[14:0], 1'b0};
            adc_sdout = m_sh[15];
            if (m_rises == W) begin
                m_last_din = m_din;
                if (m_din[15]) m_cfg_ch = m_din[14:13];
            end
        end
    end

    // Timing monitor sampled on the falling clock edge
    int  cnv_len = 0, meas_width = 0, gap = 0, meas_gap = 0, hi_sum = 0;
    bit  gap_on = 0, prev_cnv = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_cnv) begin
                cnv_len++;
            end else if (prev_cnv) begin
                meas_width = cnv_len;
                cnv_len = 0;
                gap_on = 1;
                gap = 0;
                hi_sum = 0;
            end
            if (gap_on && !adc_cnv) begin
                if (!adc_sck) gap++;
                else begin
                    gap_on = 0;
                    meas_gap = gap;
                end
            end
            if (adc_sck) hi_sum++;
            prev_cnv = adc_cnv;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input int ch, input int hold, input int k, input int prev);
        logic [15:0] snap_d;
        logic [1:0]  snap_c;
        logic [15:0] exp_din;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_chan  = 2'(ch);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R2 busy after accept", int'(cmd_ready), 0);
        chk(adc_cnv == 1'b1, "R2 cnv after accept", int'(adc_cnv), 1);
        while (!res_valid) begin
            cmd_chan = cmd_chan + 2'd1; // R8 noise while busy
            @(negedge clk);
        end
        snap_d = res_data;
        snap_c = res_chan;
        for (int i = 0; i < hold; i++) begin
            cmd_valid = 1'b1; // R7 attempt while result pending
            cmd_chan  = 2'(i);
            @(negedge clk);
            chk(res_valid && res_data == snap_d && res_chan == snap_c && !cmd_ready,
                "R7 result held", int'(res_data), int'(snap_d));
        end
        cmd_valid = 1'b0;
        chk(res_data == sample_val(prev, k), "R4 data", int'(res_data), int'(sample_val(prev, k)));
        if (k > 0) chk(res_chan == 2'(prev), "R6 tag", int'(res_chan), prev);
        chk(res_primed == (k > 0), "R6 primed", int'(res_primed), int'(k > 0));
        exp_din = {1'b1, 2'(ch), 13'd0};
        chk(m_last_din == exp_din, "R5 din word", int'(m_last_din), int'(exp_din));
        chk(meas_width == CONV, "R2 cnv width", meas_width, CONV);
        chk(meas_gap == HALF, "R3 sck lead", meas_gap, HALF);
        chk(hi_sum == W * HALF, "R3 sck high total", hi_sum, W * HALF);
        chk(cnv_rises == k + 1, "R7 R8 conversion count", cnv_rises, k + 1);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid && cmd_ready, "R7 handoff", int'(res_valid), 0);
        chk(!adc_sck && !adc_cnv, "R3 sck ends low", int'(adc_sck), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seq [NCMD] = '{0, 0, 1, 0, 2, 0, 3, 1, 1, 2, 1, 3, 2, 2, 3, 3, 0};
        int prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
        chk(!res_valid && !adc_cnv && !adc_sck && !adc_din, "R1 outputs low",
            int'({res_valid, adc_cnv, adc_sck, adc_din}), 0);
        // R8: cmd_chan moving without cmd_valid starts nothing
        for (int i = 0; i < 20; i++) begin
            cmd_chan = 2'(i);
            @(negedge clk);
        end
        chk(cnv_rises == 0 && !adc_cnv, "R8 idle chan ignored", cnv_rises, 0);
        chk(!adc_din, "R8 din idle", int'(adc_din), 0);
        prev = 0;
        for (int k = 0; k < NCMD; k++) begin
            do_cmd(seq[k], k % 4, k, prev);
            prev = seq[k];
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule